// File: doc/BRIEF.md
# Pipelined Multiply-Accumulate Slice with Partitionable Lane ALU

This block is an arithmetic slice for datapath pipelines. A signed 25 x 18 multiplier feeds a 48-bit arithmetic and logic unit, and a 48-bit accumulator register sits behind that unit. Each cycle the slice accepts one operation: a configuration code, an operation code and three operands. The result appears on the output a fixed number of enabled cycles later.

The configuration code picks one of four datapath shapes. In the first, the sign-extended product of A and B meets the C operand in one 48-bit lane. In the other three, the multiplier is skipped. A and B are joined into a second 48-bit vector, and the unit works on it and on C as one 48-bit lane, two 24-bit lanes or four 12-bit lanes. No carry or borrow crosses a lane boundary, and each lane reports its own carry flag. Lane splitting is therefore only possible when the multiplier is not used.

The operations are add, subtract, accumulate, accumulate-subtract, load-accumulator and three bitwise logic functions. A clock enable freezes the whole pipeline. A synchronous clear empties it. An asynchronous active-low reset, released synchronously outside the block, does the same.

Top module: `mac_simd_slice`

## Requirements
- R1: With configuration 00 (multiply), the vector X is the signed product of A (25-bit two's complement) and B (18-bit two's complement), sign-extended to 48 bits. Operation 000 (add) gives C + X as a single 48-bit lane.
- R2: With configurations 01, 10 and 11 (multiplier skipped), X is the 43-bit concatenation {A, B}, with A in the upper bits, sign-extended from bit 42 to 48 bits. Operation 000 gives C + X.
- R3: Operation 001 (subtract) gives C - X in each lane. The lane's carry flag is 1 exactly when the subtraction does not borrow, that is when C >= X unsigned within the lane.
- R4: Operation 010 (accumulate) gives ACC + X, and operation 111 (accumulate-subtract) gives ACC - X. ACC is the accumulator's current value, and the carry flags follow the same rules as add and subtract.
- R5: Operation 011 (load) replaces the accumulator with X and clears every carry flag.
- R6: Operations 100, 101 and 110 give C AND X, C OR X and C XOR X, and clear every carry flag.
- R7: Configuration 10 makes two independent 24-bit lanes, bits 23:0 and 47:24, with carry flags in lane_co[0] and lane_co[1]. lane_co[3:2] is 0.
- R8: Configuration 11 makes four independent 12-bit lanes, with lane k at bits 12k+11:12k and its carry flag in lane_co[k]. In configurations 00 and 01 the single lane's flag is lane_co[0], and lane_co[3:1] is 0.
- R9: An operation presented at an enabled clock edge shows on result and lane_co after the third enabled edge, counting that one.
- R10: While ce is low and srst is low, no register changes, so result and lane_co hold.
- R11: srst high at a clock edge clears every pipeline register and the accumulator, whatever ce is. rst_n low clears them at once. After either, result and lane_co read 0.
- R12: Every lane wraps modulo 2 to the power of its width. A lane of all ones plus one gives 0 with its carry flag set, and the neighbouring lanes are left unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Clock enable for all pipeline stages |
| srst | input | 1 | Synchronous clear of all registers |
| a_in | input | 25 | Operand A, two's complement |
| b_in | input | 18 | Operand B, two's complement |
| c_in | input | 48 | Operand C |
| mode_sel | input | 2 | Configuration: 00 multiply, 01 one 48-bit lane, 10 two 24-bit lanes, 11 four 12-bit lanes |
| op_sel | input | 3 | Operation code (see R1 to R6) |
| result | output | 48 | Accumulator / result register |
| lane_co | output | 4 | Per-lane carry flags |

## Verification
The assertions assume that rst_n is released away from a clock edge and that ce and srst are driven cleanly to 0 or 1 at every edge. They also assume that the operand, configuration and operation inputs carry known values whenever ce is high. The bench changes every input only on falling edges and never leaves one unknown. It mixes enabled and stalled cycles and pulses of the synchronous clear among operations, so the hold and clear properties are reached from busy pipeline states as well as idle ones.

// File: rtl/mac_slice_pkg.sv
package mac_slice_pkg;
  typedef enum logic [1:0] {
    CFG_MUL = 2'b00,
    CFG_W48 = 2'b01,
    CFG_W24 = 2'b10,
    CFG_W12 = 2'b11
  } cfg_e;

  typedef enum logic [2:0] {
    OP_ADD    = 3'b000,
    OP_SUB    = 3'b001,
    OP_ACC    = 3'b010,
    OP_LOAD   = 3'b011,
    OP_AND    = 3'b100,
    OP_OR     = 3'b101,
    OP_XOR    = 3'b110,
    OP_ACCSUB = 3'b111
  } op_e;

  function automatic logic op_is_sub(op_e o);
    return (o == OP_SUB) || (o == OP_ACCSUB);
  endfunction

  function automatic logic op_reads_acc(op_e o);
    return (o == OP_ACC) || (o == OP_ACCSUB);
  endfunction

  function automatic logic op_is_arith(op_e o);
    return (o == OP_ADD) || (o == OP_SUB) || (o == OP_ACC) || (o == OP_ACCSUB);
  endfunction
endpackage

// File: rtl/mac_in_stage.sv
module mac_in_stage
  import mac_slice_pkg::*;
#(
  parameter int A_W = 25,
  parameter int B_W = 18,
  parameter int D_W = 48
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ce,
  input  logic           srst,
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  input  logic [D_W-1:0] c_i,
  input  cfg_e           cfg_i,
  input  op_e            op_i,
  output logic [A_W-1:0] a_q,
  output logic [B_W-1:0] b_q,
  output logic [D_W-1:0] c_q,
  output cfg_e           cfg_q,
  output op_e            op_q
);
  logic [A_W-1:0] a_d;
  logic [B_W-1:0] b_d;
  logic [D_W-1:0] c_d;
  cfg_e           cfg_d;
  op_e            op_d;

  always_comb begin
    a_d   = a_q;
    b_d   = b_q;
    c_d   = c_q;
    cfg_d = cfg_q;
    op_d  = op_q;
    if (srst) begin
      a_d   = '0;
      b_d   = '0;
      c_d   = '0;
      cfg_d = CFG_MUL;
      op_d  = OP_ADD;
    end else if (ce) begin
      a_d   = a_i;
      b_d   = b_i;
      c_d   = c_i;
      cfg_d = cfg_i;
      op_d  = op_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= '0;
      b_q   <= '0;
      c_q   <= '0;
      cfg_q <= CFG_MUL;
      op_q  <= OP_ADD;
    end else begin
      a_q   <= a_d;
      b_q   <= b_d;
      c_q   <= c_d;
      cfg_q <= cfg_d;
      op_q  <= op_d;
    end
  end

  a_r10_input_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce && !srst) |=> ($stable(a_q) && $stable(b_q) && $stable(c_q)));
endmodule

// File: rtl/mac_opnd_stage.sv
module mac_opnd_stage
  import mac_slice_pkg::*;
#(
  parameter int A_W = 25,
  parameter int B_W = 18,
  parameter int D_W = 48
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ce,
  input  logic           srst,
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  input  logic [D_W-1:0] c_i,
  input  cfg_e           cfg_i,
  input  op_e            op_i,
  output logic [D_W-1:0] x_q,
  output logic [D_W-1:0] c_q,
  output cfg_e           cfg_q,
  output op_e            op_q
);
  localparam int P_W   = A_W + B_W;
  localparam int EXT_W = D_W - P_W;

  logic signed [P_W-1:0] prod;
  logic        [P_W-1:0] joined;
  logic        [D_W-1:0] x_sel;
  logic        [D_W-1:0] x_d;
  logic        [D_W-1:0] c_d;
  cfg_e                  cfg_d;
  op_e                   op_d;

  assign prod   = $signed(a_i) * $signed(b_i);
  assign joined = {a_i, b_i};

  always_comb begin
    if (cfg_i == CFG_MUL) x_sel = {{EXT_W{prod[P_W-1]}}, prod};
    else                  x_sel = {{EXT_W{joined[P_W-1]}}, joined};
  end

  always_comb begin
    x_d   = x_q;
    c_d   = c_q;
    cfg_d = cfg_q;
    op_d  = op_q;
    if (srst) begin
      x_d   = '0;
      c_d   = '0;
      cfg_d = CFG_MUL;
      op_d  = OP_ADD;
    end else if (ce) begin
      x_d   = x_sel;
      c_d   = c_i;
      cfg_d = cfg_i;
      op_d  = op_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q   <= '0;
      c_q   <= '0;
      cfg_q <= CFG_MUL;
      op_q  <= OP_ADD;
    end else begin
      x_q   <= x_d;
      c_q   <= c_d;
      cfg_q <= cfg_d;
      op_q  <= op_d;
    end
  end

  // R1: the registered product carries a clean sign extension
  a_r1_sign_extend: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !srst && cfg_i == CFG_MUL) |=>
      ((x_q[D_W-1:P_W-1] == '0) || (x_q[D_W-1:P_W-1] == '1)));

  a_r11_opnd_clear: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (x_q == '0 && c_q == '0));
endmodule

// File: rtl/mac_simd_alu.sv
module mac_simd_alu
  import mac_slice_pkg::*;
#(
  parameter int SEG_W = 12,
  parameter int NSEG  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ce,
  input  logic                  srst,
  input  logic [SEG_W*NSEG-1:0] x_i,
  input  logic [SEG_W*NSEG-1:0] c_i,
  input  cfg_e                  cfg_i,
  input  op_e                   op_i,
  output logic [SEG_W*NSEG-1:0] acc_q,
  output logic [NSEG-1:0]       co_q
);
  localparam int D_W  = SEG_W * NSEG;
  localparam int HALF = NSEG / 2;

  logic [D_W-1:0]  first_op;
  logic [D_W-1:0]  second_op;
  logic [D_W-1:0]  sum;
  logic [NSEG-1:0] cin;
  logic [NSEG-1:0] cout;
  logic [NSEG-1:0] lstart;
  logic [NSEG-1:0] lend;
  logic            sub;
  logic [D_W-1:0]  acc_d;
  logic [NSEG-1:0] co_d;
  logic [NSEG-1:0] co_calc;

  assign sub       = op_is_sub(op_i);
  assign first_op  = op_reads_acc(op_i) ? acc_q : c_i;
  assign second_op = sub ? ~x_i : x_i;

  // lane boundaries per configuration
  always_comb begin
    for (int i = 0; i < NSEG; i++) begin
      unique case (cfg_i)
        CFG_W12: begin lstart[i] = 1'b1;          lend[i] = 1'b1;              end
        CFG_W24: begin lstart[i] = (i % HALF) == 0; lend[i] = (i % HALF) == HALF-1; end
        default: begin lstart[i] = (i == 0);      lend[i] = (i == NSEG-1);     end
      endcase
    end
  end

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    if (g == 0) begin : g_first
      assign cin[g] = sub;
    end else begin : g_rest
      assign cin[g] = lstart[g] ? sub : cout[g-1];
    end
    assign {cout[g], sum[g*SEG_W +: SEG_W]} =
      {1'b0, first_op[g*SEG_W +: SEG_W]} + {1'b0, second_op[g*SEG_W +: SEG_W]}
      + {{SEG_W{1'b0}}, cin[g]};
  end

  // gather lane carry flags into the low flag bits
  always_comb begin
    co_calc = '0;
    for (int i = 0; i < NSEG; i++) begin
      if (lend[i]) begin
        unique case (cfg_i)
          CFG_W12: co_calc[i]        = cout[i];
          CFG_W24: co_calc[i / HALF] = cout[i];
          default: co_calc[0]        = cout[i];
        endcase
      end
    end
  end

  always_comb begin
    acc_d = acc_q;
    co_d  = co_q;
    if (srst) begin
      acc_d = '0;
      co_d  = '0;
    end else if (ce) begin
      co_d = '0;
      unique case (op_i)
        OP_LOAD: acc_d = x_i;
        OP_AND:  acc_d = c_i & x_i;
        OP_OR:   acc_d = c_i | x_i;
        OP_XOR:  acc_d = c_i ^ x_i;
        default: begin
          acc_d = sum;
          co_d  = co_calc;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      co_q  <= '0;
    end else begin
      acc_q <= acc_d;
      co_q  <= co_d;
    end
  end

  a_r11_sync_clear: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (acc_q == '0 && co_q == '0));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce && !srst) |=> ($stable(acc_q) && $stable(co_q)));

  a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !srst && op_i == OP_LOAD) |=> (acc_q == $past(x_i) && co_q == '0));

  a_r6_logic_noflag: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !srst && !op_is_arith(op_i)) |=> (co_q == '0));

  a_r4_acc_wide: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !srst && op_i == OP_ACC && cfg_i == CFG_W48) |=>
      (acc_q == D_W'($past(acc_q) + $past(x_i))));

  a_r7_upper_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !srst && cfg_i == CFG_W24) |=> (co_q[NSEG-1:HALF] == '0));

  a_r8_single_lane_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !srst && (cfg_i == CFG_W48 || cfg_i == CFG_MUL)) |=> (co_q[NSEG-1:1] == '0));
endmodule

// File: rtl/mac_simd_slice.sv
module mac_simd_slice
  import mac_slice_pkg::*;
#(
  parameter int A_W   = 25,
  parameter int B_W   = 18,
  parameter int SEG_W = 12,
  parameter int NSEG  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ce,
  input  logic                  srst,
  input  logic [A_W-1:0]        a_in,
  input  logic [B_W-1:0]        b_in,
  input  logic [SEG_W*NSEG-1:0] c_in,
  input  logic [1:0]            mode_sel,
  input  logic [2:0]            op_sel,
  output logic [SEG_W*NSEG-1:0] result,
  output logic [NSEG-1:0]       lane_co
);
  localparam int D_W = SEG_W * NSEG;

  logic [A_W-1:0] s1_a;
  logic [B_W-1:0] s1_b;
  logic [D_W-1:0] s1_c;
  cfg_e           s1_cfg;
  op_e            s1_op;
  logic [D_W-1:0] s2_x;
  logic [D_W-1:0] s2_c;
  cfg_e           s2_cfg;
  op_e            s2_op;

  mac_in_stage #(.A_W(A_W), .B_W(B_W), .D_W(D_W)) u_in (
    .clk(clk), .rst_n(rst_n), .ce(ce), .srst(srst),
    .a_i(a_in), .b_i(b_in), .c_i(c_in),
    .cfg_i(cfg_e'(mode_sel)), .op_i(op_e'(op_sel)),
    .a_q(s1_a), .b_q(s1_b), .c_q(s1_c), .cfg_q(s1_cfg), .op_q(s1_op)
  );

  mac_opnd_stage #(.A_W(A_W), .B_W(B_W), .D_W(D_W)) u_opnd (
    .clk(clk), .rst_n(rst_n), .ce(ce), .srst(srst),
    .a_i(s1_a), .b_i(s1_b), .c_i(s1_c), .cfg_i(s1_cfg), .op_i(s1_op),
    .x_q(s2_x), .c_q(s2_c), .cfg_q(s2_cfg), .op_q(s2_op)
  );

  mac_simd_alu #(.SEG_W(SEG_W), .NSEG(NSEG)) u_alu (
    .clk(clk), .rst_n(rst_n), .ce(ce), .srst(srst),
    .x_i(s2_x), .c_i(s2_c), .cfg_i(s2_cfg), .op_i(s2_op),
    .acc_q(result), .co_q(lane_co)
  );
endmodule

// File: tb/test_mac_simd_slice.sv
`timescale 1ns/1ps
module test_mac_simd_slice;
  localparam longint M48 = 64'h0000_FFFF_FFFF_FFFF;

  typedef struct packed {
    logic [24:0] a;
    logic [17:0] b;
    logic [47:0] c;
    logic [1:0]  m;
    logic [2:0]  o;
  } rec_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce = 1'b0;
  logic        srst = 1'b0;
  logic [24:0] a_in = '0;
  logic [17:0] b_in = '0;
  logic [47:0] c_in = '0;
  logic [1:0]  mode_sel = '0;
  logic [2:0]  op_sel = '0;
  logic [47:0] result;
  logic [3:0]  lane_co;

  int    total = 0;
  int    bad = 0;
  bit    done = 0;
  string tag = "R11";

  always #4 clk = ~clk;

  mac_simd_slice i_mac_simd_slice (
    .clk(clk), .rst_n(rst_n), .ce(ce), .srst(srst),
    .a_in(a_in), .b_in(b_in), .c_in(c_in),
    .mode_sel(mode_sel), .op_sel(op_sel),
    .result(result), .lane_co(lane_co)
  );

  function automatic longint sx(longint v, int w);
    return (v <<< (64 - w)) >>> (64 - w);
  endfunction

  // behavioural evaluation of one operation against the accumulator
  function automatic logic [51:0] exec(rec_t r, logic [47:0] acc);
    longint x, f, s, t, lm, res;
    int lw, n;
    logic [3:0] co;
    if (r.m == 2'b00) x = (sx(longint'(r.a), 25) * sx(longint'(r.b), 18)) & M48;
    else              x = sx((longint'(r.a) << 18) | longint'(r.b), 43) & M48;
    lw = (r.m == 2'b10) ? 24 : (r.m == 2'b11) ? 12 : 48;
    n  = 48 / lw;
    lm = (64'sd1 << lw) - 1;
    res = 0;
    co  = '0;
    case (r.o)
      3'b011: res = x;
      3'b100: res = longint'(r.c) & x;
      3'b101: res = longint'(r.c) | x;
      3'b110: res = longint'(r.c) ^ x;
      default: begin
        for (int l = 0; l < n; l++) begin
          f = ((r.o == 3'b010 || r.o == 3'b111) ? longint'(acc) : longint'(r.c));
          f = (f >> (l * lw)) & lm;
          s = (x >> (l * lw)) & lm;
          if (r.o == 3'b001 || r.o == 3'b111) t = f + ((~s) & lm) + 1;
          else                                t = f + s;
          co[l] = t[lw];
          res = res | ((t & lm) << (l * lw));
        end
      end
    endcase
    return {co, res[47:0]};
  endfunction

  rec_t        m1, m2;
  logic [47:0] mp;
  logic [3:0]  mc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || srst) begin
      m1 <= '0; m2 <= '0; mp <= '0; mc <= '0;
    end else if (rst_n && ce) begin
      {mc, mp} <= exec(m2, mp);
      m2 <= m1;
      m1 <= '{a: a_in, b: b_in, c: c_in, m: mode_sel, o: op_sel};
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      total++;
      if (result !== mp || lane_co !== mc) begin
        bad++;
        $display("FAIL %s: result=%h co=%b expected result=%h co=%b", tag, result, lane_co, mp, mc);
      end
    end
  end

  task automatic step(input logic [1:0] m, input logic [2:0] o, input logic [24:0] a,
                      input logic [17:0] b, input logic [47:0] c,
                      input logic e = 1'b1, input logic s = 1'b0);
    @(negedge clk);
    mode_sel = m; op_sel = o; a_in = a; b_in = b; c_in = c; ce = e; srst = s;
  endtask

  function automatic logic [47:0] r48();
    return {$urandom, $urandom};
  endfunction

  task automatic rand_run(input int cnt, input logic [1:0] m, input int opsel, input bit rce, input bit rsr);
    for (int i = 0; i < cnt; i++) begin
      logic [2:0] o;
      logic [1:0] mm;
      o  = (opsel < 0) ? 3'($urandom) : 3'(opsel);
      mm = (m === 2'bxx) ? 2'($urandom) : m;
      step(mm, o, 25'($urandom), 18'($urandom), r48(),
           rce ? (($urandom % 3) != 0) : 1'b1, rsr ? (($urandom % 13) == 0) : 1'b0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    total++;
    if (result !== 48'h0 || lane_co !== 4'h0) begin
      bad++;
      $display("FAIL R11: reset result=%h co=%b expected result=0 co=0", result, lane_co);
    end
    rst_n = 1'b1;

    tag = "R9 latency";
    step(2'b01, 3'b011, 25'h0, 18'h5, 48'h0);
    step(2'b01, 3'b010, 25'h0, 18'h1, 48'h0, 1'b0);
    step(2'b01, 3'b010, 25'h0, 18'h1, 48'h0);
    step(2'b01, 3'b010, 25'h0, 18'h2, 48'h0);
    step(2'b01, 3'b000, 25'h0, 18'h0, 48'h0);
    step(2'b01, 3'b000, 25'h0, 18'h0, 48'h0);

    tag = "R1 multiply";
    step(2'b00, 3'b000, 25'h1000000, 18'h20000, 48'h0);
    step(2'b00, 3'b000, 25'h1000000, 18'h1FFFF, 48'h1);
    step(2'b00, 3'b000, 25'h1FFFFFF, 18'h3FFFF, 48'hFFFF_FFFF_FFFF);
    step(2'b00, 3'b000, 25'h0FFFFFF, 18'h1FFFF, 48'h8000_0000_0000);
    rand_run(60, 2'b00, 0, 0, 0);

    tag = "R2 bypass";
    step(2'b01, 3'b000, 25'h1000000, 18'h0, 48'h0);
    rand_run(60, 2'b01, 0, 0, 0);

    tag = "R3 subtract";
    step(2'b01, 3'b001, 25'h0, 18'h1, 48'h1);
    step(2'b01, 3'b001, 25'h0, 18'h2, 48'h1);
    rand_run(40, 2'b01, 1, 0, 0);
    rand_run(20, 2'b00, 1, 0, 0);

    tag = "R4 accumulate";
    step(2'b00, 3'b011, 25'h3, 18'h7, 48'h0);
    rand_run(30, 2'b00, 2, 0, 0);
    rand_run(30, 2'b01, 7, 0, 0);

    tag = "R5 load";
    rand_run(20, 2'bxx, 3, 0, 0);

    tag = "R6 logic";
    rand_run(20, 2'bxx, 4, 0, 0);
    rand_run(20, 2'bxx, 5, 0, 0);
    rand_run(20, 2'bxx, 6, 0, 0);

    tag = "R7 two lanes";
    step(2'b10, 3'b000, 25'h0, 18'h1, 48'h0000_00FF_FFFF);
    rand_run(80, 2'b10, -1, 0, 0);

    tag = "R8 four lanes";
    step(2'b11, 3'b001, 25'h0, 18'h1, 48'h0);
    rand_run(80, 2'b11, -1, 0, 0);

    tag = "R12 wrap";
    step(2'b11, 3'b000, 25'h0040040, 18'h01001, 48'hFFFF_FFFF_FFFF);
    step(2'b11, 3'b000, 25'h0, 18'h1, 48'h0000_0000_0FFF);
    step(2'b10, 3'b000, 25'h0000040, 18'h1, 48'hFFFF_FFFF_FFFF);
    step(2'b01, 3'b000, 25'h0, 18'h1, 48'hFFFF_FFFF_FFFF);
    step(2'b11, 3'b011, 25'h1FFFFFF, 18'h3FFFF, 48'h0);
    step(2'b11, 3'b010, 25'h0, 18'h1, 48'h0);
    rand_run(4, 2'b01, 0, 0, 0);

    tag = "R10 enable";
    rand_run(150, 2'bxx, -1, 1, 0);

    tag = "R11 clear";
    rand_run(150, 2'bxx, -1, 1, 1);
    step(2'b01, 3'b011, 25'h1, 18'h1, 48'h0, 1'b0, 1'b1);

    tag = "R9 mixed";
    rand_run(300, 2'bxx, -1, 0, 0);
    step(2'b01, 3'b000, 25'h0, 18'h0, 48'h0);
    repeat (4) @(negedge clk);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule